// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

This block moves bit fields of 0 to 24 bits between a 24-bit accumulator and a word-addressed memory. A command carries a field descriptor packed into one 24-bit word: a 5-bit length in the top bits, a 5-bit offset below it, and a 14-bit word address in the low bits. Bits are numbered from the most significant end, so offset 0 names bit 23 of the stored word. A field whose last bit falls past position 23 continues at the most significant bit of the next word. The unit reads the one or two words it needs through a request/response memory port. A load returns the field right-aligned in an otherwise cleared accumulator. A store writes the low accumulator bits back with a read-modify-write.

The descriptor can take its length or offset from an index word when the field holds the escape value 31. The auto-advance forms instead compare the descriptor against a limit descriptor. When there is room they perform the access, return a descriptor moved past the field, and flag a skip.

Commands enter on a valid/ready port that accepts one command at a time. `cmd_ready` is high only while the unit is idle. A result is offered on `rsp_valid` and held unchanged until `rsp_ready` is seen high at a clock edge. Memory requests likewise hold their address, write flag and data until `mem_req_ready`. Read data is taken in a cycle where both `mem_rsp_valid` and `mem_rsp_ready` are high.

Top module: `fieldop_unit`

## Requirements
- R1: For op 0 (load), the field is bits offset through offset+length-1, counted from the most significant bit (bit 0 = word bit 23). The response accumulator holds the field right-aligned with all higher bits zero. The descriptor is laid out as length = bits [23:19], offset = bits [18:14], address = bits [13:0].
- R2: When offset+length exceeds 24, the field continues into the word at address+1, which wraps modulo 2^14. Its remaining bits start at that word's bit 23.
- R3: For op 1 (store), the low `length` accumulator bits replace the field and every other memory bit keeps its value. Each affected word is read first and written afterwards, and two-word writes go in ascending address order.
- R4: In ops 0 and 1, a descriptor length of 31 is replaced by index bits [23:19], and an offset of 31 is replaced by index bits [18:14].
- R5: If the effective offset is above 23, the effective length is above 24, or the op code is 5, 6 or 7, the response has trap=1 and skip=0. In that case the unit issues no memory request and returns the command's accumulator and descriptor unchanged.
- R6: A zero-length field issues no memory request. A load of it returns zero, and a store of it leaves memory unchanged.
- R7: Ops 2, 3 and 4 apply no escape substitution, so a length or offset of 31 in them traps.
- R8: For ops 2 to 4, let room = (limit address - address) × 24 + (limit offset - offset), evaluated as a signed value. If room is less than the length, the unit makes no access, returns skip=0 and trap=0, and returns the accumulator and descriptor unchanged.
- R9: Otherwise ops 2 and 3 load or store exactly as ops 0 and 1 do, using the original descriptor, and return skip=1. The returned descriptor has offset+length as its offset; if that sum exceeds 23, the offset is the sum minus 24 and the address is incremented.
- R10: Op 4 applies the same limit check and descriptor advance as R8/R9 but makes no memory access and leaves the accumulator unchanged.
- R11: After reset, cmd_ready=1, rsp_valid=0 and mem_req_valid=0. While a response or a memory request is stalled, it is held stable. Ops 0 and 1 return skip=0 and the unchanged descriptor, and a store returns the unchanged accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command taken at this edge |
| cmd_op | input | 3 | 0 load, 1 store, 2 load-advance, 3 store-advance, 4 advance only |
| cmd_desc | input | 24 | Field descriptor |
| cmd_limit | input | 24 | Limit descriptor for ops 2 to 4 |
| cmd_index | input | 24 | Index word supplying escaped length/offset |
| cmd_acc | input | 24 | Accumulator value |
| rsp_valid | output | 1 | Result offered |
| rsp_ready | input | 1 | Result consumed |
| rsp_acc | output | 24 | Resulting accumulator |
| rsp_desc | output | 24 | Resulting descriptor |
| rsp_skip | output | 1 | Auto-advance form performed |
| rsp_trap | output | 1 | Descriptor check failed |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory request taken |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 14 | Word address |
| mem_req_wdata | output | 24 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Unit waiting for read data |
| mem_rsp_data | input | 24 | Read data |

## Verification
The descriptor check and the limit check are both evaluated on the same command in the same cycle. An auto-advance command with an out-of-range field and too little room must therefore trap without skipping. The bench provokes this by issuing auto-advance commands with escape or oversized fields against tight or negative limits, and expects trap=1, skip=0 and no memory traffic. The descriptor wrap into the next word also coincides with a two-word access in one command. The bench aims fields that end exactly on the boundary or cross it, including at the top address. It judges both the returned descriptor and the two memory words against a bit-by-bit reference model.

// File: rtl/fieldop_pkg.sv
package fieldop_pkg;
  localparam int FLD_W  = 5;
  localparam int ADDR_W = 14;
  localparam int WORD_W = 2 * FLD_W + ADDR_W;
  localparam int DBL_W  = 2 * WORD_W;
  localparam int SH_W   = $clog2(DBL_W + 1);
  localparam int RM_W   = ADDR_W + FLD_W + 3;

  localparam logic [FLD_W-1:0] ESC     = '1;
  localparam logic [FLD_W:0]   WLEN    = (FLD_W+1)'(WORD_W);
  localparam logic [FLD_W:0]   WLAST   = (FLD_W+1)'(WORD_W - 1);

  typedef enum logic [2:0] {
    OP_LOAD      = 3'd0,
    OP_STORE     = 3'd1,
    OP_LOAD_ADV  = 3'd2,
    OP_STORE_ADV = 3'd3,
    OP_ADVANCE   = 3'd4
  } op_e;

  typedef struct packed {
    logic [FLD_W-1:0]  len;
    logic [FLD_W-1:0]  off;
    logic [ADDR_W-1:0] addr;
  } desc_t;

  typedef struct packed {
    logic              trap;
    logic              skip;
    logic              access;
    logic              is_store;
    logic              ld;
    logic              two;
    logic [FLD_W-1:0]  len;
    logic [FLD_W-1:0]  off;
    logic [ADDR_W-1:0] addr;
    desc_t             next_desc;
  } plan_t;
endpackage

// File: rtl/fieldop_decode.sv
module fieldop_decode
  import fieldop_pkg::*;
(
  input  logic [2:0]        op,
  input  logic [WORD_W-1:0] desc,
  input  logic [WORD_W-1:0] limit,
  input  logic [WORD_W-1:0] index,
  output plan_t             plan
);
  desc_t d, l, x;
  logic  automode, known, bad, short_room;
  logic [FLD_W-1:0] len, off;
  logic [FLD_W:0]   sum;
  logic signed [RM_W-1:0] adiff, odiff, room, lenx;
  desc_t adv;
  logic  decode_unused;

  assign d = desc_t'(desc);
  assign l = desc_t'(limit);
  assign x = desc_t'(index);
  assign decode_unused = ^{x.addr, l.len};

  always_comb begin
    automode = (op == OP_LOAD_ADV) || (op == OP_STORE_ADV) || (op == OP_ADVANCE);
    known    = (op <= OP_ADVANCE);
    len = d.len;
    off = d.off;
    if (!automode && d.len == ESC) len = x.len;
    if (!automode && d.off == ESC) off = x.off;
    bad = !known || ({1'b0, off} > WLAST) || ({1'b0, len} > WLEN);

    adiff = $signed(RM_W'(l.addr)) - $signed(RM_W'(d.addr));
    odiff = $signed(RM_W'(l.off))  - $signed(RM_W'(d.off));
    room  = adiff * $signed(RM_W'(WORD_W)) + odiff;
    lenx  = $signed(RM_W'(len));
    short_room = automode && (room < lenx);

    sum = {1'b0, off} + {1'b0, len};
    adv.len = d.len;
    if (sum > WLAST) begin
      adv.off  = FLD_W'(sum - WLEN);
      adv.addr = d.addr + ADDR_W'(1);
    end else begin
      adv.off  = FLD_W'(sum);
      adv.addr = d.addr;
    end

    plan.trap      = bad;
    plan.skip      = !bad && automode && !short_room;
    plan.access    = !bad && !short_room && (op != OP_ADVANCE) && (len != '0);
    plan.is_store  = (op == OP_STORE) || (op == OP_STORE_ADV);
    plan.ld        = !bad && !short_room && ((op == OP_LOAD) || (op == OP_LOAD_ADV));
    plan.two       = (sum > WLEN);
    plan.len       = len;
    plan.off       = off;
    plan.addr      = d.addr;
    plan.next_desc = plan.skip ? adv : d;
  end
endmodule

// File: rtl/fieldop_merge.sv
module fieldop_merge
  import fieldop_pkg::*;
(
  input  logic [WORD_W-1:0] w_hi,
  input  logic [WORD_W-1:0] w_lo,
  input  logic [FLD_W-1:0]  off,
  input  logic [FLD_W-1:0]  len,
  input  logic [WORD_W-1:0] acc,
  output logic [WORD_W-1:0] field,
  output logic [WORD_W-1:0] new_hi,
  output logic [WORD_W-1:0] new_lo
);
  localparam logic [SH_W-1:0] DBL = SH_W'(DBL_W);

  logic [DBL_W-1:0] cat, mask, place, ext, ins, src;
  logic [SH_W-1:0]  shift;

  always_comb begin
    cat   = {w_hi, w_lo};
    shift = DBL - SH_W'(off) - SH_W'(len);
    mask  = (DBL_W'(1) << len) - DBL_W'(1);
    place = mask << shift;
    ext   = (cat >> shift) & mask;
    src   = {{WORD_W{1'b0}}, acc} & mask;
    ins   = (cat & ~place) | (src << shift);
  end

  assign field  = ext[WORD_W-1:0];
  assign new_hi = ins[DBL_W-1:WORD_W];
  assign new_lo = ins[WORD_W-1:0];
endmodule

// File: rtl/fieldop_unit.sv
module fieldop_unit
  import fieldop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [WORD_W-1:0] cmd_desc,
  input  logic [WORD_W-1:0] cmd_limit,
  input  logic [WORD_W-1:0] cmd_index,
  input  logic [WORD_W-1:0] cmd_acc,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_acc,
  output logic [WORD_W-1:0] rsp_desc,
  output logic              rsp_skip,
  output logic              rsp_trap,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [WORD_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [WORD_W-1:0] mem_rsp_data
);
  typedef enum logic [2:0] {
    S_IDLE, S_RD0, S_RW0, S_RD1, S_RW1, S_WR0, S_WR1, S_RESP
  } st_e;

  st_e   st;
  plan_t plan, pl;
  logic [WORD_W-1:0] acc_q, w0, w1, field, nw0, nw1;
  logic  plan_unused;

  assign plan_unused = pl.access;

  fieldop_decode u_decode (
    .op    (cmd_op),
    .desc  (cmd_desc),
    .limit (cmd_limit),
    .index (cmd_index),
    .plan  (plan)
  );

  fieldop_merge u_merge (
    .w_hi   (w0),
    .w_lo   (w1),
    .off    (pl.off),
    .len    (pl.len),
    .acc    (acc_q),
    .field  (field),
    .new_hi (nw0),
    .new_lo (nw1)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      pl    <= '0;
      acc_q <= '0;
      w0    <= '0;
      w1    <= '0;
    end else begin
      case (st)
        S_IDLE: if (cmd_valid) begin
          pl    <= plan;
          acc_q <= cmd_acc;
          st    <= plan.access ? S_RD0 : S_RESP;
        end
        S_RD0: if (mem_req_ready) st <= S_RW0;
        S_RW0: if (mem_rsp_valid) begin
          w0 <= mem_rsp_data;
          if (pl.two)           st <= S_RD1;
          else if (pl.is_store) st <= S_WR0;
          else                  st <= S_RESP;
        end
        S_RD1: if (mem_req_ready) st <= S_RW1;
        S_RW1: if (mem_rsp_valid) begin
          w1 <= mem_rsp_data;
          st <= pl.is_store ? S_WR0 : S_RESP;
        end
        S_WR0: if (mem_req_ready) st <= pl.two ? S_WR1 : S_RESP;
        S_WR1: if (mem_req_ready) st <= S_RESP;
        S_RESP: if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_RD0) || (st == S_RD1) || (st == S_WR0) || (st == S_WR1);
  assign mem_req_we    = (st == S_WR0) || (st == S_WR1);
  assign mem_req_addr  = ((st == S_RD1) || (st == S_WR1)) ? pl.addr + ADDR_W'(1) : pl.addr;
  assign mem_req_wdata = (st == S_WR1) ? nw1 : nw0;
  assign mem_rsp_ready = (st == S_RW0) || (st == S_RW1);

  assign rsp_valid = (st == S_RESP);
  assign rsp_acc   = pl.ld ? field : acc_q;
  assign rsp_desc  = WORD_W'(pl.next_desc);
  assign rsp_skip  = pl.skip;
  assign rsp_trap  = pl.trap;
endmodule

// File: rtl/fieldop_unit_chk.sv
module fieldop_unit_chk
  import fieldop_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [WORD_W-1:0] rsp_acc,
  input logic [WORD_W-1:0] rsp_desc,
  input logic              rsp_skip,
  input logic              rsp_trap,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [WORD_W-1:0] mem_req_wdata
);
  logic              req_seen, wr_seen;
  logic [ADDR_W-1:0] last_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_seen <= 1'b0;
      wr_seen  <= 1'b0;
      last_wr  <= '0;
    end else if (cmd_valid && cmd_ready) begin
      req_seen <= 1'b0;
      wr_seen  <= 1'b0;
    end else if (mem_req_valid && mem_req_ready) begin
      req_seen <= 1'b1;
      if (mem_req_we) begin
        wr_seen <= 1'b1;
        last_wr <= mem_req_addr;
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata)) else $error("req hold"); // R11
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_acc) && $stable(rsp_desc)
      && $stable(rsp_skip) && $stable(rsp_trap)) else $error("rsp hold"); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !rsp_valid && !mem_req_valid) else $error("idle quiet"); // R11
  AST_TRAP_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_trap |-> !rsp_skip) else $error("trap skip"); // R5
  AST_TRAP_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_trap |-> !req_seen) else $error("trap mem"); // R5
  AST_WR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready && mem_req_we && wr_seen
      |-> mem_req_addr == last_wr + ADDR_W'(1)) else $error("write order"); // R3
  AST_ADV_OFF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_skip |-> rsp_desc[ADDR_W +: FLD_W] <= FLD_W'(WORD_W - 1)) else $error("adv off"); // R9
endmodule

bind fieldop_unit fieldop_unit_chk u_chk (.*);

// File: tb/fieldop_unit_bench.sv
module fieldop_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NRAND = 400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [23:0] cmd_desc = '0, cmd_limit = '0, cmd_index = '0, cmd_acc = '0;
  logic rsp_valid, rsp_ready = 1'b0, rsp_skip, rsp_trap;
  logic [23:0] rsp_acc, rsp_desc;
  logic mem_req_valid, mem_req_ready, mem_req_we, mem_rsp_valid, mem_rsp_ready;
  logic [13:0] mem_req_addr;
  logic [23:0] mem_req_wdata, mem_rsp_data;

  int tests = 0, fails = 0, req_cnt;
  logic [23:0] mem  [0:16383];
  logic [23:0] gold [0:16383];

  always #(CLK_PERIOD/2) clk = ~clk;

  fieldop_unit u_fieldop_unit (.*);

  function automatic logic [23:0] pat(int i);
    return 24'(i * 32'h9E3779 ^ (i << 7) ^ 32'h5A5A5A);
  endfunction

  initial for (int i = 0; i < 16384; i++) gold[i] = pat(i);

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16384; i++) mem[i] <= pat(i);
      mem_req_ready <= 1'b0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
      req_cnt       <= 0;
    end else begin
      mem_req_ready <= ($urandom_range(0, 3) != 0);
      if (mem_rsp_valid && mem_rsp_ready) mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        req_cnt <= req_cnt + 1;
        if (mem_req_we) mem[mem_req_addr] <= mem_req_wdata;
        else begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= mem[mem_req_addr];
        end
      end
    end
  end

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Reference: bit-serial walk over the field, MSB-first numbering
  task automatic ref_model(input logic [2:0] op, input logic [23:0] d, lim, idx, acc,
                           output logic trap, skip, output logic [23:0] eacc, edesc,
                           output int ecnt);
    int len, off, a, a1, room, sum, words;
    logic autom, perform;
    len = int'(d[23:19]); off = int'(d[18:14]); a = int'(d[13:0]);
    a1 = (a + 1) % 16384;
    autom = (op >= 3'd2 && op <= 3'd4);
    if (!autom && len == 31) len = int'(idx[23:19]);
    if (!autom && off == 31) off = int'(idx[18:14]);
    trap = (op > 3'd4) || off > 23 || len > 24;
    room = (int'(lim[13:0]) - a) * 24 + (int'(lim[18:14]) - int'(d[18:14]));
    perform = !trap && !(autom && room < len);
    skip = perform && autom;
    eacc = acc; edesc = d; ecnt = 0;
    words = (off + len > 24) ? 2 : 1;
    if (perform && (op == 3'd0 || op == 3'd2)) begin
      eacc = '0;
      for (int i = 0; i < len; i++) begin
        int p = off + i;
        eacc[len-1-i] = (p < 24) ? gold[a][23-p] : gold[a1][47-p];
      end
      if (len > 0) ecnt = words;
    end
    if (perform && (op == 3'd1 || op == 3'd3) && len > 0) begin
      for (int i = 0; i < len; i++) begin
        int p = off + i;
        if (p < 24) gold[a][23-p] = acc[len-1-i];
        else        gold[a1][47-p] = acc[len-1-i];
      end
      ecnt = 2 * words;
    end
    if (skip) begin
      sum = off + len;
      if (sum > 23) begin
        edesc[18:14] = 5'(sum - 24);
        edesc[13:0]  = 14'(a + 1);
      end else edesc[18:14] = 5'(sum);
    end
  endtask

  task automatic run(string tag, logic [2:0] op, logic [23:0] d, lim, idx, acc);
    logic etrap, eskip;
    logic [23:0] eacc, edesc;
    int ecnt, base, a, a1;
    a = int'(d[13:0]); a1 = (a + 1) % 16384;
    ref_model(op, d, lim, idx, acc, etrap, eskip, eacc, edesc, ecnt);
    @(negedge clk);
    cmd_op = op; cmd_desc = d; cmd_limit = lim; cmd_index = idx; cmd_acc = acc;
    cmd_valid = 1'b1;
    base = req_cnt;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    repeat ($urandom_range(0, 2)) @(negedge clk);
    rsp_ready = 1'b1;
    check(tag, "trap", 32'(rsp_trap), 32'(etrap));
    check(tag, "skip", 32'(rsp_skip), 32'(eskip));
    check(tag, "acc",  32'(rsp_acc),  32'(eacc));
    check(tag, "desc", 32'(rsp_desc), 32'(edesc));
    @(negedge clk);
    rsp_ready = 1'b0;
    check(tag, "mem requests", 32'(req_cnt - base), 32'(ecnt));
    check(tag, "word0", 32'(mem[a]),  32'(gold[a]));
    check(tag, "word1", 32'(mem[a1]), 32'(gold[a1]));
  endtask

  function automatic logic [23:0] mk(int len, int off, int addr);
    return {5'(len), 5'(off), 14'(addr)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", "reset cmd_ready", 32'(cmd_ready), 32'd1);
    check("R11", "reset rsp_valid", 32'(rsp_valid), 32'd0);
    check("R11", "reset mem_req_valid", 32'(mem_req_valid), 32'd0);

    run("R1",  3'd0, mk(8, 4, 10),      '0, '0, 24'hFFFFFF);
    run("R1",  3'd0, mk(24, 0, 11),     '0, '0, 24'h0);
    run("R2",  3'd0, mk(12, 18, 20),    '0, '0, 24'h0);
    run("R2",  3'd0, mk(10, 20, 16383), '0, '0, 24'h0);
    run("R3",  3'd1, mk(7, 3, 30),      '0, '0, 24'hABCDEF);
    run("R3",  3'd1, mk(20, 15, 16383), '0, '0, 24'h123456);
    run("R4",  3'd0, mk(6, 31, 40),     '0, mk(0, 7, 0), 24'h0);
    run("R4",  3'd1, mk(31, 31, 41),    '0, mk(9, 22, 0), 24'h3FF);
    run("R5",  3'd0, mk(4, 24, 50),     '0, '0, 24'h777777);
    run("R5",  3'd1, mk(25, 0, 51),     '0, '0, 24'h777777);
    run("R5",  3'd6, mk(4, 2, 52),      mk(0, 0, 60), '0, 24'h111111);
    run("R6",  3'd0, mk(0, 23, 53),     '0, '0, 24'hFFFFFF);
    run("R6",  3'd1, mk(0, 5, 54),      '0, '0, 24'hFFFFFF);
    run("R7",  3'd2, mk(31, 0, 55),     mk(0, 0, 99), mk(4, 4, 0), 24'h0);
    run("R7",  3'd3, mk(31, 31, 56),    mk(0, 0, 2), '0, 24'h0);
    run("R8",  3'd2, mk(8, 20, 5),      mk(0, 22, 5), '0, 24'h55AA55);
    run("R8",  3'd3, mk(8, 0, 9),       mk(0, 0, 3), '0, 24'h55AA55);
    run("R9",  3'd2, mk(8, 20, 5),      mk(0, 4, 6), '0, 24'h0);
    run("R9",  3'd3, mk(24, 0, 7),      mk(0, 0, 8), '0, 24'hC3C3C3);
    run("R10", 3'd4, mk(5, 21, 12),     mk(0, 0, 20), '0, 24'h010203);
    run("R10", 3'd4, mk(5, 21, 12),     mk(0, 1, 12), '0, 24'h010203);
    run("R11", 3'd1, mk(3, 1, 13),      '0, '0, 24'h5);

    for (int n = 0; n < NRAND; n++) begin
      logic [2:0] op;
      int len, off, addr;
      logic [23:0] lim;
      op   = ($urandom_range(0, 19) == 0) ? 3'($urandom_range(5, 7)) : 3'($urandom_range(0, 4));
      off  = ($urandom_range(0, 9) == 0) ? 31 : $urandom_range(0, 23);
      len  = ($urandom_range(0, 9) == 0) ? 31 :
             ($urandom_range(0, 14) == 0) ? $urandom_range(0, 30) : $urandom_range(0, 24);
      addr = $urandom_range(0, 40);
      lim  = mk(0, $urandom_range(0, 23), addr + $urandom_range(0, 2));
      run(op == 3'd0 ? "R1" : op == 3'd1 ? "R3" : op == 3'd4 ? "R10" : "R9",
          op, mk(len, off, addr), lim, 24'($urandom()), 24'($urandom()));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule